// File: doc/BRIEF.md
# Vector Element Repacker

This block takes one 64-bit word, treats it as a packed vector of source elements, and produces a packed vector of destination elements that have a different width. Each element passes through unchanged. It is then zero-extended when the destination width is larger, or cut to its low-order bits when the destination width is smaller. The source width and the destination width are chosen independently from 8, 16, 32 and 64 bits.

A mode bit sets the element order. In little-endian mode, element 0 sits at the least significant end of both the source word and the result. In big-endian mode, element 0 sits at the most significant end of both. The vector length sets how many elements are moved. It is clamped to the number of elements that fit at the wider of the two widths. Destination lanes at or beyond the vector length are written as zero.

The result and its valid flag are registered. They appear one clock after the input strobe, so the block can drop into a pipeline as a single stage.

Top module: `vec_repack`

## Requirements
- R1: With `big_end`=0, source element k is taken from bits [k*S +: S] and destination element k is written to bits [k*D +: D], where S and D are the source and destination widths. For source 0x0123_4567_89ab_cdef, length 4, 8-bit to 16-bit, the result is 0x0089_00ab_00cd_00ef.
- R2: With `big_end`=1, element k is counted from the most significant end of both the source and the result. The same input as in R1 gives 0x0001_0023_0045_0067.
- R3: `src_ew` and `dst_ew` are independent 2-bit width codes: 00=8, 01=16, 10=32, 11=64 bits. Every one of the 16 combinations is accepted.
- R4: When the destination is wider than the source, each element is zero-extended.
- R5: When the destination is narrower than the source, each element keeps its low-order D bits.
- R6: The effective length is min(`vec_len`, 64/max(S,D)). A `vec_len` of 0 gives an all-zero result.
- R7: Destination lanes whose index is at or beyond the effective length are zero.
- R8: In both modes, when S equals D and the effective length fills the word, `out_data` equals `in_data`.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `out_data` carries that cycle's result. Synchronous active-high `rst` clears `out_valid` and `out_data` to zero.
- R10: In a cycle with `in_valid` low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_data | input | 64 | Source word |
| src_ew | input | 2 | Source element width code |
| dst_ew | input | 2 | Destination element width code |
| vec_len | input | 4 | Requested vector length |
| big_end | input | 1 | 1 = element 0 at the most significant end |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Packed destination vector |

## Verification
Directed words with distinct byte values are run at each width pair in both modes. They separate a lane-order fault from a value fault. One example is the 8-to-16 pattern, whose little-endian and big-endian results differ in every lane. Equal-width runs at full length must give back the input. Any reversal inside an element, or any swap of lanes, breaks that identity. Lengths of 0, partial and over-limit probe the clamp and the zeroing of the upper lanes. Random words, width codes, lengths and modes cover all pairings against a bench model.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int WORD_W  = 64;
  localparam int BYTE_W  = 8;
  localparam int WCODE_W = 2;

  typedef enum logic [WCODE_W-1:0] {
    EW_B8  = 2'b00,
    EW_B16 = 2'b01,
    EW_B32 = 2'b10,
    EW_B64 = 2'b11
  } ew_e;

  function automatic int ew_bits(input logic [WCODE_W-1:0] code);
    return BYTE_W << code;
  endfunction

  function automatic logic [WORD_W-1:0] ew_mask(input logic [WCODE_W-1:0] code);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < WORD_W; b++) m[b] = (b < ew_bits(code));
    return m;
  endfunction
endpackage

// File: rtl/vrp_elem_pick.sv
module vrp_elem_pick
  import vrp_pkg::*;
#(
  parameter int DATA_W = vrp_pkg::WORD_W,
  parameter int IDX    = 0
) (
  input  logic [DATA_W-1:0]  src,
  input  logic [WCODE_W-1:0] src_ew,
  input  logic               big_end,
  output logic [DATA_W-1:0]  elem
);
  int unsigned el_bits;
  int unsigned el_cnt;
  int unsigned el_shift;

  always_comb begin
    el_bits  = ew_bits(src_ew);
    el_cnt   = DATA_W / el_bits;
    el_shift = big_end ? DATA_W - (IDX + 1) * el_bits : IDX * el_bits;
    if (IDX >= el_cnt) elem = '0;
    else               elem = (src >> el_shift) & ew_mask(src_ew);
  end
endmodule

// File: rtl/vrp_lane_pack.sv
module vrp_lane_pack
  import vrp_pkg::*;
#(
  parameter int DATA_W = vrp_pkg::WORD_W,
  parameter int LANES  = DATA_W / vrp_pkg::BYTE_W,
  parameter int VL_W   = 4
) (
  input  logic [DATA_W-1:0]  elems [LANES],
  input  logic [WCODE_W-1:0] dst_ew,
  input  logic [VL_W-1:0]    vl_eff,
  input  logic               big_end,
  output logic [DATA_W-1:0]  packed_out
);
  int unsigned ln_bits;
  int unsigned ln_cnt;

  always_comb begin
    ln_bits    = ew_bits(dst_ew);
    ln_cnt     = DATA_W / ln_bits;
    packed_out = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(vl_eff) && i < ln_cnt) begin
        packed_out = packed_out |
          ((elems[i] & ew_mask(dst_ew)) <<
           (big_end ? DATA_W - (i + 1) * ln_bits : i * ln_bits));
      end
    end
  end
endmodule

// File: rtl/vec_repack.sv
module vec_repack
  import vrp_pkg::*;
#(
  parameter int DATA_W = vrp_pkg::WORD_W,
  parameter int VL_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        src_ew,
  input  logic [1:0]        dst_ew,
  input  logic [VL_W-1:0]   vec_len,
  input  logic              big_end,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int LANES = DATA_W / BYTE_W;

  logic [WCODE_W-1:0] wide_ew;
  logic [VL_W-1:0]    vl_limit;
  logic [VL_W-1:0]    vl_eff;
  logic [DATA_W-1:0]  picked [LANES];
  logic [DATA_W-1:0]  packed_w;

  always_comb begin
    wide_ew  = (src_ew > dst_ew) ? src_ew : dst_ew;
    vl_limit = VL_W'(DATA_W / ew_bits(wide_ew));
    vl_eff   = (vec_len > vl_limit) ? vl_limit : vec_len;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    vrp_elem_pick #(.DATA_W(DATA_W), .IDX(g)) u_pick (
      .src     (in_data),
      .src_ew  (src_ew),
      .big_end (big_end),
      .elem    (picked[g])
    );
  end

  vrp_lane_pack #(.DATA_W(DATA_W), .LANES(LANES), .VL_W(VL_W)) u_pack (
    .elems      (picked),
    .dst_ew     (dst_ew),
    .vl_eff     (vl_eff),
    .big_end    (big_end),
    .packed_out (packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= packed_w;
    end
  end

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R8
  identity_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_ew == dst_ew && int'(vec_len) >= DATA_W / ew_bits(src_ew))
    |=> out_data == $past(in_data));
  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_len == '0) |=> out_data == '0);
endmodule

// File: tb/vec_repack_tb.sv
`timescale 1ns/1ps
module vec_repack_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0]  src_ew = '0;
  logic [1:0]  dst_ew = '0;
  logic [3:0]  vec_len = '0;
  logic        big_end = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vec_repack u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .src_ew(src_ew), .dst_ew(dst_ew), .vec_len(vec_len), .big_end(big_end),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] wmask(int bits);
    return (bits >= 64) ? '1 : ((64'd1 << bits) - 64'd1);
  endfunction

  function automatic logic [63:0] model(logic [63:0] s, logic [1:0] sw,
                                        logic [1:0] dw, logic [3:0] vl, logic be);
    int sb = 8 << sw;
    int db = 8 << dw;
    int lim = 64 / ((sb > db) ? sb : db);
    int n = (int'(vl) > lim) ? lim : int'(vl);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) begin
      logic [63:0] e;
      e = be ? (s >> (64 - (k + 1) * sb)) : (s >> (k * sb));
      e = e & wmask(sb) & wmask(db);
      r = r | (be ? (e << (64 - (k + 1) * db)) : (e << (k * db)));
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [63:0] s, logic [1:0] sw, logic [1:0] dw,
                     logic [3:0] vl, logic be, logic [63:0] exp);
    in_data = s; src_ew = sw; dst_ew = dw; vec_len = vl; big_end = be;
    in_valid = 1'b1;
    @(negedge clk);
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, exp);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] pat;
    void'($urandom(32'd1234));
    pat = 64'h0123_4567_89ab_cdef;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset data", out_data, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    run("R1", pat, 2'b00, 2'b01, 4'd4, 1'b0, 64'h0089_00ab_00cd_00ef);
    run("R2", pat, 2'b00, 2'b01, 4'd4, 1'b1, 64'h0001_0023_0045_0067);
    for (int w = 0; w < 4; w++) begin
      run("R8 le", pat, 2'(w), 2'(w), 4'd8, 1'b0, pat);
      run("R8 be", pat, 2'(w), 2'(w), 4'd8, 1'b1, pat);
    end
    run("R4", pat, 2'b00, 2'b11, 4'd1, 1'b0, 64'h0000_0000_0000_00ef);
    run("R4 be", pat, 2'b01, 2'b10, 4'd2, 1'b1, 64'h0000_0123_0000_4567);
    run("R5", pat, 2'b11, 2'b00, 4'd1, 1'b0, 64'h0000_0000_0000_00ef);
    run("R5 be", pat, 2'b10, 2'b01, 4'd2, 1'b1, 64'h4567_cdef_0000_0000);
    run("R6 clamp", pat, 2'b01, 2'b01, 4'd15, 1'b0, pat);
    run("R6 zero", pat, 2'b00, 2'b00, 4'd0, 1'b1, 64'd0);
    run("R7", pat, 2'b00, 2'b00, 4'd2, 1'b0, 64'h0000_0000_0000_cdef);
    run("R7 be", pat, 2'b00, 2'b00, 4'd3, 1'b1, 64'h0123_4500_0000_0000);

    @(negedge clk);
    check("R9 drop", {63'd0, out_valid}, 64'd0);
    in_data = ~pat; vec_len = 4'd8; src_ew = 2'b00; dst_ew = 2'b00;
    @(negedge clk);
    check("R10 hold", out_data, 64'h0123_4500_0000_0000);

    for (int t = 0; t < 300; t++) begin
      logic [63:0] s;
      logic [1:0] sw, dw;
      logic [3:0] vl;
      logic be;
      s  = {$urandom(), $urandom()};
      sw = 2'($urandom_range(3));
      dw = 2'($urandom_range(3));
      vl = 4'($urandom_range(15));
      be = 1'($urandom_range(1));
      run("R3 random", s, sw, dw, vl, be, model(s, sw, dw, vl, be));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 rst clear", out_data, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule